// File: doc/BRIEF.md
# Store Address and Routing Unit

This unit is the store stage of a simple RISC pipeline. Each cycle it may take one 32-bit immediate-format instruction together with two source operands already read from the register file: the base value and the data value. It decodes the 6-bit opcode and the signed 16-bit displacement, forms the effective byte address, and checks that the address suits the access size. It then turns the instruction into a write request with byte enables.

A normal store is routed to the cached memory port. There a cache may absorb it without any immediate bus activity. An I/O-form store is routed to the peripheral port instead, where it always results in exactly one bus write. When the unit is built for a core without a data cache, the I/O forms are handled exactly like the normal forms. A store whose address is misaligned produces no write. It raises a one-cycle exception strobe with a code and the faulting address. Any opcode that is not a store passes through without effect.

Each output port uses a valid/ready handshake. The unit holds one store at a time and takes no new instruction until that write has been accepted.

Top module: `store_route_unit`

## Requirements
- R1: The opcode is taken from instruction bits [5:0] and the displacement from bits [21:6]. Bits [31:22] hold the register index fields; they do not affect the request, the exception or the handshake.
- R2: The effective address is the base operand plus the displacement sign-extended to 32 bits, wrapping modulo 2^32.
- R3: A word store (default opcodes 0x15 normal and 0x35 I/O) with address bits [1:0] = 0 issues a request carrying the whole data operand, with byte enables 4'b1111.
- R4: A word store with address bits [1:0] != 0 issues no request. It raises the exception strobe with code 4'h1 (misaligned address) and the computed address.
- R5: A halfword store (opcode 0x0d normal, 0x2d I/O) with address bit 0 clear writes data operand bits [15:0]. It uses bytes 1:0 (enables 4'b0011, data in bits [15:0]) when address bit 1 is 0. It uses bytes 3:2 (enables 4'b1100, data in bits [31:16]) when address bit 1 is 1. Unused lanes are zero.
- R6: A halfword store with address bit 0 set issues no request and raises exception code 4'h1 with the computed address.
- R7: With a data cache present (HAS_DCACHE=1), normal stores go only to the cached port and I/O-form stores go only to the peripheral port, one request per store.
- R8: With HAS_DCACHE=0, I/O-form stores go to the cached port exactly as normal stores do, and the peripheral port never asserts valid.
- R9: A request stays valid with stable address, data and byte enables until the handshake, and it completes exactly one transfer.
- R10: instr_ready is low from the cycle after a store is accepted until the cycle after its write handshake.
- R11: The exception strobe lasts one cycle per faulting store, never coincides with a request, and leaves instr_ready high.
- R12: An opcode that is not one of the four store opcodes produces no request and no exception, and instr_ready stays high.
- R13: After reset both request valids and the exception strobe are low and instr_ready is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| instr_valid | input | 1 | Instruction and operands are present |
| instr_ready | output | 1 | Unit can accept an instruction |
| instr | input | 32 | Immediate-format instruction word |
| base_val | input | 32 | Base operand value |
| store_val | input | 32 | Data operand value |
| mem_valid | output | 1 | Cached-port write request |
| mem_ready | input | 1 | Cached port accepts the request |
| mem_addr | output | 32 | Cached-port byte address |
| mem_wdata | output | 32 | Cached-port write data, lane aligned |
| mem_be | output | 4 | Cached-port byte enables |
| pio_valid | output | 1 | Peripheral-port write request |
| pio_ready | input | 1 | Peripheral port accepts the request |
| pio_addr | output | 32 | Peripheral-port byte address |
| pio_wdata | output | 32 | Peripheral-port write data, lane aligned |
| pio_be | output | 4 | Peripheral-port byte enables |
| fault_valid | output | 1 | One-cycle exception strobe |
| fault_code | output | 4 | Exception code |
| fault_addr | output | 32 | Faulting effective address |

## Verification
The hardest case to reach is a held request whose port ready stays low for several cycles, while the stage upstream keeps offering the next store. Only in that case do R9 and R10 interact. The bench drives each port's ready from its own pseudo-random bit pattern, so long stalls occur on both ports. Its driver offers each instruction as soon as instr_ready rises, with displacements chosen to cross the zero and wrap boundaries. A second instance built without a data cache sees the same instructions with ready held high, which checks R8 against the same expected stream with the port swapped.

// File: rtl/store_route_pkg.sv
package store_route_pkg;

    localparam int XLEN      = 32;
    localparam int BE_W      = XLEN / 8;
    localparam int OPC_W     = 6;
    localparam int IMM_W     = 16;
    localparam int IMM_LSB   = OPC_W;
    localparam int IMM_MSB   = IMM_LSB + IMM_W - 1;
    localparam int CODE_W    = 4;

    localparam logic [CODE_W-1:0] FAULT_MISALIGNED = 4'h1;

    typedef enum logic [1:0] {
        SZ_NONE = 2'd0,
        SZ_HALF = 2'd1,
        SZ_WORD = 2'd2
    } size_e;

    typedef struct packed {
        logic              req_v;
        logic              req_io;
        logic [XLEN-1:0]   addr;
        logic [XLEN-1:0]   wdata;
        logic [BE_W-1:0]   be;
        logic              flt_v;
        logic [CODE_W-1:0] flt_code;
        logic [XLEN-1:0]   flt_addr;
    } route_state_t;

endpackage

// File: rtl/store_decode.sv
module store_decode
    import store_route_pkg::*;
#(
    parameter logic [OPC_W-1:0] OP_WORD    = 6'h15,
    parameter logic [OPC_W-1:0] OP_WORD_IO = 6'h35,
    parameter logic [OPC_W-1:0] OP_HALF    = 6'h0d,
    parameter logic [OPC_W-1:0] OP_HALF_IO = 6'h2d
) (
    input  logic [IMM_MSB:0] low_bits,
    output size_e            size,
    output logic             io_form,
    output logic [XLEN-1:0]  disp
);
    logic [OPC_W-1:0] opc;
    logic [IMM_W-1:0] imm;

    assign opc  = low_bits[OPC_W-1:0];
    assign imm  = low_bits[IMM_MSB:IMM_LSB];
    assign disp = {{(XLEN-IMM_W){imm[IMM_W-1]}}, imm};

    always_comb begin
        size    = SZ_NONE;
        io_form = 1'b0;
        unique case (opc)
            OP_WORD:    begin size = SZ_WORD; io_form = 1'b0; end
            OP_WORD_IO: begin size = SZ_WORD; io_form = 1'b1; end
            OP_HALF:    begin size = SZ_HALF; io_form = 1'b0; end
            OP_HALF_IO: begin size = SZ_HALF; io_form = 1'b1; end
            default:    begin size = SZ_NONE; io_form = 1'b0; end
        endcase
    end
endmodule

// File: rtl/store_agu.sv
module store_agu
    import store_route_pkg::*;
(
    input  logic [XLEN-1:0] base,
    input  logic [XLEN-1:0] disp,
    input  logic [XLEN-1:0] value,
    input  size_e           size,
    output logic [XLEN-1:0] ea,
    output logic            aligned,
    output logic [XLEN-1:0] lane_data,
    output logic [BE_W-1:0] lane_be
);
    localparam int HALF_W = XLEN / 2;
    localparam int HBE_W  = BE_W / 2;

    assign ea = base + disp;

    always_comb begin
        aligned   = 1'b0;
        lane_data = '0;
        lane_be   = '0;
        case (size)
            SZ_WORD: begin
                aligned   = (ea[1:0] == 2'b00);
                lane_data = value;
                lane_be   = '1;
            end
            SZ_HALF: begin
                aligned = ~ea[0];
                if (ea[1]) begin
                    lane_data = {value[HALF_W-1:0], {HALF_W{1'b0}}};
                    lane_be   = {{HBE_W{1'b1}}, {HBE_W{1'b0}}};
                end else begin
                    lane_data = {{HALF_W{1'b0}}, value[HALF_W-1:0]};
                    lane_be   = {{HBE_W{1'b0}}, {HBE_W{1'b1}}};
                end
            end
            default: begin
                aligned   = 1'b0;
                lane_data = '0;
                lane_be   = '0;
            end
        endcase
    end
endmodule

// File: rtl/store_route_unit.sv
module store_route_unit
    import store_route_pkg::*;
#(
    parameter bit               HAS_DCACHE = 1'b1,
    parameter logic [OPC_W-1:0] OP_WORD    = 6'h15,
    parameter logic [OPC_W-1:0] OP_WORD_IO = 6'h35
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              instr_valid,
    output logic              instr_ready,
    input  logic [XLEN-1:0]   instr,
    input  logic [XLEN-1:0]   base_val,
    input  logic [XLEN-1:0]   store_val,
    output logic              mem_valid,
    input  logic              mem_ready,
    output logic [XLEN-1:0]   mem_addr,
    output logic [XLEN-1:0]   mem_wdata,
    output logic [BE_W-1:0]   mem_be,
    output logic              pio_valid,
    input  logic              pio_ready,
    output logic [XLEN-1:0]   pio_addr,
    output logic [XLEN-1:0]   pio_wdata,
    output logic [BE_W-1:0]   pio_be,
    output logic              fault_valid,
    output logic [CODE_W-1:0] fault_code,
    output logic [XLEN-1:0]   fault_addr
);
    route_state_t st_d, st_q;

    size_e           dec_size;
    logic            dec_io;
    logic            route_io;
    logic [XLEN-1:0] dec_disp;
    logic [XLEN-1:0] agu_ea;
    logic            agu_ok;
    logic [XLEN-1:0] agu_data;
    logic [BE_W-1:0] agu_be;
    logic [XLEN-IMM_MSB-2:0] unused_reg_fields;

    assign unused_reg_fields = instr[XLEN-1:IMM_MSB+1];

    store_decode #(
        .OP_WORD    (OP_WORD),
        .OP_WORD_IO (OP_WORD_IO)
    ) u_dec (
        .low_bits (instr[IMM_MSB:0]),
        .size     (dec_size),
        .io_form  (dec_io),
        .disp     (dec_disp)
    );

    store_agu u_agu (
        .base      (base_val),
        .disp      (dec_disp),
        .value     (store_val),
        .size      (dec_size),
        .ea        (agu_ea),
        .aligned   (agu_ok),
        .lane_data (agu_data),
        .lane_be   (agu_be)
    );

    generate
        if (HAS_DCACHE) begin : g_split
            assign route_io = dec_io;
        end else begin : g_flat
            logic unused_io_form;
            assign unused_io_form = dec_io;
            assign route_io       = 1'b0;
        end
    endgenerate

    always_comb begin
        logic accept;
        logic done;
        st_d        = st_q;
        st_d.flt_v  = 1'b0;
        done        = st_q.req_v && (st_q.req_io ? pio_ready : mem_ready);
        accept      = instr_valid && !st_q.req_v;
        if (done) begin
            st_d.req_v = 1'b0;
        end
        if (accept && dec_size != SZ_NONE) begin
            if (agu_ok) begin
                st_d.req_v  = 1'b1;
                st_d.req_io = route_io;
                st_d.addr   = agu_ea;
                st_d.wdata  = agu_data;
                st_d.be     = agu_be;
            end else begin
                st_d.flt_v    = 1'b1;
                st_d.flt_code = FAULT_MISALIGNED;
                st_d.flt_addr = agu_ea;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign instr_ready = ~st_q.req_v;
    assign mem_valid   = st_q.req_v & ~st_q.req_io;
    assign pio_valid   = st_q.req_v &  st_q.req_io;
    assign mem_addr    = st_q.addr;
    assign mem_wdata   = st_q.wdata;
    assign mem_be      = st_q.be;
    assign pio_addr    = st_q.addr;
    assign pio_wdata   = st_q.wdata;
    assign pio_be      = st_q.be;
    assign fault_valid = st_q.flt_v;
    assign fault_code  = st_q.flt_code;
    assign fault_addr  = st_q.flt_addr;
endmodule

// File: rtl/store_route_chk.sv
module store_route_chk
    import store_route_pkg::*;
#(
    parameter bit HAS_DCACHE = 1'b1
) (
    input logic              clk,
    input logic              rst_n,
    input logic              instr_ready,
    input logic              mem_valid,
    input logic              mem_ready,
    input logic [XLEN-1:0]   mem_addr,
    input logic [XLEN-1:0]   mem_wdata,
    input logic [BE_W-1:0]   mem_be,
    input logic              pio_valid,
    input logic              pio_ready,
    input logic [XLEN-1:0]   pio_addr,
    input logic [XLEN-1:0]   pio_wdata,
    input logic [BE_W-1:0]   pio_be,
    input logic              fault_valid,
    input logic [CODE_W-1:0] fault_code,
    input logic [XLEN-1:0]   fault_addr
);
    assert_mem_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_valid && !mem_ready) |=> (mem_valid && $stable(mem_addr)
                                       && $stable(mem_wdata) && $stable(mem_be)));

    assert_pio_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (pio_valid && !pio_ready) |=> (pio_valid && $stable(pio_addr)
                                       && $stable(pio_wdata) && $stable(pio_be)));

    assert_one_port_R7: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({mem_valid, pio_valid}));

    assert_no_pio_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !HAS_DCACHE |-> !pio_valid);

    assert_busy_stall_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_valid || pio_valid) |-> !instr_ready);

    assert_fault_alone_R11: assert property (@(posedge clk) disable iff (!rst_n)
        fault_valid |-> (!mem_valid && !pio_valid && instr_ready
                         && fault_code == FAULT_MISALIGNED));

    assert_fault_addr_R4: assert property (@(posedge clk) disable iff (!rst_n)
        fault_valid |-> (fault_addr[1:0] != 2'b00));

    assert_word_aligned_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_valid && mem_be == 4'b1111) |-> (mem_addr[1:0] == 2'b00));

    assert_half_lanes_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_valid && mem_be != 4'b1111) |->
            (!mem_addr[0] && mem_be == (mem_addr[1] ? 4'b1100 : 4'b0011)));
endmodule

bind store_route_unit store_route_chk #(.HAS_DCACHE(HAS_DCACHE)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .instr_ready (instr_ready),
    .mem_valid   (mem_valid),
    .mem_ready   (mem_ready),
    .mem_addr    (mem_addr),
    .mem_wdata   (mem_wdata),
    .mem_be      (mem_be),
    .pio_valid   (pio_valid),
    .pio_ready   (pio_ready),
    .pio_addr    (pio_addr),
    .pio_wdata   (pio_wdata),
    .pio_be      (pio_be),
    .fault_valid (fault_valid),
    .fault_code  (fault_code),
    .fault_addr  (fault_addr)
);

// File: tb/sim_store_route_unit.sv
module sim_store_route_unit;
    localparam logic [5:0] OPW  = 6'h15;
    localparam logic [5:0] OPWI = 6'h35;
    localparam logic [5:0] OPH  = 6'h0d;
    localparam logic [5:0] OPHI = 6'h2d;

    typedef struct {
        int          kind;   // 0 cached, 1 peripheral, 2 fault
        logic [31:0] addr;
        logic [31:0] data;
        logic [3:0]  be;
        string       req;
    } item_t;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        instr_valid = 1'b0;
    logic [31:0] instr = '0;
    logic [31:0] base_val = '0;
    logic [31:0] store_val = '0;
    logic        mem_ready = 1'b0;
    logic        pio_ready = 1'b0;
    logic [15:0] lfsr = 16'hace1;

    logic        instr_ready, mem_valid, pio_valid, fault_valid;
    logic [31:0] mem_addr, mem_wdata, pio_addr, pio_wdata, fault_addr;
    logic [3:0]  mem_be, pio_be, fault_code;

    logic        b_ready, b_mvalid, b_pvalid, b_fvalid;
    logic [31:0] b_maddr, b_mdata, b_paddr, b_pdata, b_faddr;
    logic [3:0]  b_mbe, b_pbe, b_fcode;

    int checks = 0;
    int fails = 0;
    int cycles = 0;
    item_t q0[$];
    item_t q1[$];

    always #2 clk = ~clk;

    store_route_unit #(.HAS_DCACHE(1'b1)) u0 (
        .clk(clk), .rst_n(rst_n), .instr_valid(instr_valid), .instr_ready(instr_ready),
        .instr(instr), .base_val(base_val), .store_val(store_val),
        .mem_valid(mem_valid), .mem_ready(mem_ready), .mem_addr(mem_addr),
        .mem_wdata(mem_wdata), .mem_be(mem_be),
        .pio_valid(pio_valid), .pio_ready(pio_ready), .pio_addr(pio_addr),
        .pio_wdata(pio_wdata), .pio_be(pio_be),
        .fault_valid(fault_valid), .fault_code(fault_code), .fault_addr(fault_addr));

    store_route_unit #(.HAS_DCACHE(1'b0)) u1 (
        .clk(clk), .rst_n(rst_n), .instr_valid(instr_valid), .instr_ready(b_ready),
        .instr(instr), .base_val(base_val), .store_val(store_val),
        .mem_valid(b_mvalid), .mem_ready(1'b1), .mem_addr(b_maddr),
        .mem_wdata(b_mdata), .mem_be(b_mbe),
        .pio_valid(b_pvalid), .pio_ready(1'b1), .pio_addr(b_paddr),
        .pio_wdata(b_pdata), .pio_be(b_pbe),
        .fault_valid(b_fvalid), .fault_code(b_fcode), .fault_addr(b_faddr));

    task automatic check(input bit ok, input string req, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    // pseudo-random ready stalls, changed just after the rising edge
    always @(posedge clk) begin
        cycles <= cycles + 1;
        lfsr   <= {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
    end
    always @(posedge clk) begin
        #1;
        mem_ready = lfsr[0] | lfsr[3];
        pio_ready = lfsr[1] & lfsr[5];
    end

    task automatic compare(ref item_t q[$], input int kind, input logic [31:0] a,
                           input logic [31:0] d, input logic [3:0] be, input string tag);
        item_t e;
        if (q.size() == 0) begin
            check(1'b0, "R9", {tag, " unexpected event kind"}, 32'(kind), 32'hffffffff);
            return;
        end
        e = q.pop_front();
        check(e.kind == kind, e.req, {tag, " port/fault kind"}, 32'(kind), 32'(e.kind));
        check(a == e.addr, e.req, {tag, " address"}, a, e.addr);
        check(d == e.data, e.req, {tag, " data/code"}, d, e.data);
        check(be == e.be, e.req, {tag, " byte enables"}, 32'(be), 32'(e.be));
    endtask

    // scoreboard monitor
    always @(negedge clk) begin
        if (rst_n) begin
            if (mem_valid && mem_ready) compare(q0, 0, mem_addr, mem_wdata, mem_be, "u0");
            if (pio_valid && pio_ready) compare(q0, 1, pio_addr, pio_wdata, pio_be, "u0");
            if (fault_valid) compare(q0, 2, fault_addr, 32'(fault_code), 4'h0, "u0");
            if (b_mvalid) compare(q1, 0, b_maddr, b_mdata, b_mbe, "u1");
            if (b_pvalid) compare(q1, 1, b_paddr, b_pdata, b_pbe, "u1");
            if (b_fvalid) compare(q1, 2, b_faddr, 32'(b_fcode), 4'h0, "u1");
        end
    end

    // driver: computes expectation from the requirements, then offers the instruction
    task automatic send(input logic [5:0] op, input logic [15:0] imm, input logic [31:0] base,
                        input logic [31:0] val, input logic [9:0] regs, input string req);
        item_t e;
        logic [31:0] ea;
        bit is_word, is_half, is_io, ok;
        ea      = base + {{16{imm[15]}}, imm};
        is_word = (op == OPW) || (op == OPWI);
        is_half = (op == OPH) || (op == OPHI);
        is_io   = (op == OPWI) || (op == OPHI);
        ok      = is_word ? (ea[1:0] == 2'b00) : (is_half ? !ea[0] : 1'b0);
        e.req   = req;
        if (is_word || is_half) begin
            if (!ok) begin
                e.kind = 2; e.addr = ea; e.data = 32'h1; e.be = 4'h0;
            end else begin
                e.kind = is_io ? 1 : 0;
                e.addr = ea;
                if (is_word) begin
                    e.data = val; e.be = 4'b1111;
                end else if (ea[1]) begin
                    e.data = {val[15:0], 16'h0}; e.be = 4'b1100;
                end else begin
                    e.data = {16'h0, val[15:0]}; e.be = 4'b0011;
                end
            end
            q0.push_back(e);
            if (e.kind == 1) e.kind = 0;   // R8: no cache, I/O form is a normal store
            q1.push_back(e);
        end
        @(negedge clk);
        while (!instr_ready) @(negedge clk);
        instr       = {regs, imm, op};
        base_val    = base;
        store_val   = val;
        instr_valid = 1'b1;
        @(negedge clk);
        instr_valid = 1'b0;
        instr       = {~regs, 16'h5a5a, 6'h3f};
        if ((is_word || is_half) && ok)
            check(instr_ready == 1'b0, "R10", "ready low while store pending",
                  32'(instr_ready), 32'h0);
        else if (is_word || is_half)
            check(instr_ready == 1'b1, "R11", "ready high after fault", 32'(instr_ready), 32'h1);
        else
            check(instr_ready == 1'b1 && !mem_valid && !pio_valid && !fault_valid, "R12",
                  "non-store ignored", {28'h0, instr_ready, mem_valid, pio_valid, fault_valid},
                  32'h8);
    endtask

    initial begin : watchdog
        wait (cycles > 100000);
        fails++;
        $display("FAIL watchdog: actual %0d cycles expected < 100000", cycles);
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin : main
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check(instr_ready && !mem_valid && !pio_valid && !fault_valid, "R13", "reset state",
              {28'h0, instr_ready, mem_valid, pio_valid, fault_valid}, 32'h8);

        send(OPW,  16'h0064, 32'h0000_1000, 32'hdead_beef, 10'h0c5, "R3");
        send(OPWI, 16'h0008, 32'h8000_0000, 32'h1234_5678, 10'h0c5, "R7");
        send(OPH,  16'h0000, 32'h0000_2000, 32'hcafe_b0ba, 10'h111, "R5");
        send(OPH,  16'h0002, 32'h0000_2000, 32'hcafe_b0ba, 10'h111, "R5");
        send(OPHI, 16'h0006, 32'h0000_4000, 32'h0000_a5c3, 10'h3ff, "R7");
        send(OPW,  16'h0002, 32'h0000_1000, 32'h1111_1111, 10'h000, "R4");
        send(OPW,  16'h0001, 32'h0000_1000, 32'h1111_1111, 10'h000, "R4");
        send(OPH,  16'h0003, 32'h0000_1000, 32'h2222_2222, 10'h000, "R6");
        send(OPHI, 16'h0001, 32'h0000_1000, 32'h2222_2222, 10'h000, "R6");
        send(OPW,  16'hfffc, 32'h0000_0010, 32'h3333_3333, 10'h0aa, "R2");
        send(OPWI, 16'h8000, 32'h0000_0000, 32'h4444_4444, 10'h0aa, "R2");
        send(OPW,  16'h0004, 32'hffff_fffc, 32'h5555_5555, 10'h0aa, "R2");
        send(6'h04, 16'h0010, 32'h0000_1000, 32'h6666_6666, 10'h000, "R12");
        send(6'h0d ^ 6'h20 ^ 6'h01, 16'h0000, 32'h0, 32'h0, 10'h000, "R12");
        // R1: register index fields must not change the result
        send(OPW,  16'h0010, 32'h0000_3000, 32'h7777_7777, 10'h000, "R1");
        send(OPW,  16'h0010, 32'h0000_3000, 32'h7777_7777, 10'h3ff, "R1");
        send(OPH,  16'h0012, 32'h0000_3000, 32'h8888_9999, 10'h2a5, "R1");
        // back-to-back mixed stream under random stalls (R9, R10)
        for (int i = 0; i < 60; i++) begin
            logic [5:0]  op;
            logic [31:0] r;
            r = 32'h9e37_79b9 * (i + 1);
            case (i % 5)
                0: op = OPW;
                1: op = OPWI;
                2: op = OPH;
                3: op = OPHI;
                default: op = 6'h2e;
            endcase
            send(op, {r[31:20], r[3:0]}, {r[15:4], 20'h0}, r ^ 32'h5bd1_e995,
                 r[25:16], "R9");
        end
        repeat (200) begin
            if (q0.size() == 0 && q1.size() == 0) break;
            @(negedge clk);
        end
        check(q0.size() == 0, "R9", "u0 pending expectations drained", 32'(q0.size()), 32'h0);
        check(q1.size() == 0, "R8", "u1 pending expectations drained", 32'(q1.size()), 32'h0);
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule